// File: doc/BRIEF.md
# One-Time-Programmable Region Protection Controller

This block holds the 1024-byte one-time-programmable byte space of a serial flash device as a register array. It also decides, for every byte program request, whether that request may change the array. The space is cut into 32 regions of 32 bytes, each aligned on a 32-byte boundary. The space can never be erased. A byte may be programmed many times, but programming can only clear bits: the stored byte becomes the old byte AND the new data.

A program request is judged against four things: the write-enable latch, the address range, a global freeze input and a per-region lock bit. The lock bits are stored inside the array itself, in the four bytes at offsets 0x10 to 0x13. An accepted request either changes the byte or raises a sticky program-error flag. In both cases the write-enable latch is cleared. Read requests return the stored byte one cycle later. Command decoding and serial shifting are left to the surrounding logic, which drives the request strobes.

Top module: `otp_prot_ctrl`

## Requirements
- R1: After reset every byte of the array reads 0xFF, `wel_o` is 0 and `perr_o` is 0.
- R2: `rd_vld_o` is 1 exactly one cycle after `rd_vld_i` is 1. For an in-range address, `rd_data_o` then shows the byte as stored before that clock edge, so a program accepted in the same cycle is not yet visible. Reads at out-of-range addresses return an undefined value.
- R3: A successful program sets the addressed byte to its old value AND `prog_data_i`. No bit ever changes from 0 to 1.
- R4: A program request made while `wel_o` is 0 is ignored. The array and `perr_o` do not change, and the latch does not change unless a set request arrives in the same cycle.
- R5: A program request whose address has any bit at position 10 or above set is out of range and ignored. The array and `perr_o` do not change, and `wel_o` stays 1.
- R6: An in-range program request made while `wel_o` is 1 and `freeze_i` is 1 fails. The array does not change, `perr_o` becomes 1 and `wel_o` becomes 0.
- R7: Region r covers offsets 32*r to 32*r+31. Its lock bit is bit (r mod 8) of the byte at offset 0x10 + (r div 8). A value of 0 means the region is locked. A program request to a locked region fails, with the same effects as R6. Programs to other regions proceed as normal.
- R8: Region 0 holds the lock bytes. When bit 0 of the byte at 0x10 is 0, the lock bytes themselves can no longer be changed.
- R9: `wen_set_i` sets the latch and `wen_clr_i` clears it. If both arrive in the same cycle, set wins. Every accepted in-range request clears the latch, and this takes priority over a set request in the same cycle. A program request is always judged on the latch value from before the current edge.
- R10: Once `perr_o` is 1 it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wen_set_i | input | 1 | Set the write-enable latch |
| wen_clr_i | input | 1 | Clear the write-enable latch |
| freeze_i | input | 1 | Global freeze; blocks all programming |
| prog_vld_i | input | 1 | Byte program request strobe |
| prog_addr_i | input | ADDR_W (12) | Program byte address |
| prog_data_i | input | BYTE_W (8) | Program data |
| rd_vld_i | input | 1 | Read request strobe |
| rd_addr_i | input | ADDR_W (12) | Read byte address |
| rd_vld_o | output | 1 | Read data valid |
| rd_data_o | output | BYTE_W (8) | Read data |
| wel_o | output | 1 | Write-enable latch state |
| perr_o | output | 1 | Sticky program-error flag |

## Verification
A read and a program can target the same byte in the same cycle. The bench issues both strobes on one edge, to a byte that still holds 0xFF. The scoreboard expects the read to return the old value 0xFF, and a follow-up read to return the new data. A latch-set request can also coincide with a program request while the latch is 0. The bench checks that the program is dropped and that the latch is left at 1.

// File: rtl/otp_pkg.sv
package otp_pkg;
    localparam int unsigned OTP_BYTES    = 1024;
    localparam int unsigned REGION_BYTES = 32;
    localparam int unsigned LOCK_BASE    = 16;
    localparam int unsigned BYTE_W       = 8;
    localparam int unsigned ADDR_W       = 12;
endpackage

// File: rtl/otp_addr_dec.sv
module otp_addr_dec #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned OFF_W  = 10,
    parameter int unsigned RG_W   = 5
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              in_range_o,
    output logic [OFF_W-1:0]  off_o,
    output logic [RG_W-1:0]   region_o
);
    assign off_o    = addr_i[OFF_W-1:0];
    assign region_o = addr_i[OFF_W-1 -: RG_W];

    generate
        if (ADDR_W > OFF_W) begin : g_hi
            assign in_range_o = (addr_i[ADDR_W-1:OFF_W] == '0);
        end else begin : g_full
            assign in_range_o = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/otp_lock_sel.sv
module otp_lock_sel #(
    parameter int unsigned OFF_W     = 10,
    parameter int unsigned RG_W      = 5,
    parameter int unsigned BYTE_W    = 8,
    parameter int unsigned LOCK_BASE = 16
) (
    input  logic [RG_W-1:0]   region_i,
    input  logic [BYTE_W-1:0] lk_byte_i,
    output logic [OFF_W-1:0]  lk_off_o,
    output logic              locked_o
);
    localparam int unsigned LB_W = $clog2(BYTE_W);

    logic [RG_W-1:0] byte_idx;
    assign byte_idx = region_i >> LB_W;
    assign lk_off_o = OFF_W'(LOCK_BASE) + OFF_W'(byte_idx);
    // a cleared lock bit marks the region as protected
    assign locked_o = ~lk_byte_i[region_i[LB_W-1:0]];
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
    parameter int unsigned DEPTH  = 1024,
    parameter int unsigned OFF_W  = 10,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [OFF_W-1:0]  wr_off_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [OFF_W-1:0]  rd_off_i,
    output logic [BYTE_W-1:0] rd_data_o,
    input  logic [OFF_W-1:0]  lk_off_i,
    output logic [BYTE_W-1:0] lk_data_o
);
    logic [BYTE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '1;
        end else if (wr_en_i) begin
            mem_q[wr_off_i] <= mem_q[wr_off_i] & wr_data_i;
        end
    end

    assign rd_data_o = mem_q[rd_off_i];
    assign lk_data_o = mem_q[lk_off_i];

    // R3
    and_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (mem_q[$past(wr_off_i)] == ($past(mem_q[wr_off_i]) & $past(wr_data_i))));
endmodule

// File: rtl/otp_prot_ctrl.sv
module otp_prot_ctrl #(
    parameter int unsigned ADDR_W       = otp_pkg::ADDR_W,
    parameter int unsigned DEPTH        = otp_pkg::OTP_BYTES,
    parameter int unsigned REGION_BYTES = otp_pkg::REGION_BYTES,
    parameter int unsigned LOCK_BASE    = otp_pkg::LOCK_BASE,
    parameter int unsigned BYTE_W       = otp_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen_set_i,
    input  logic              wen_clr_i,
    input  logic              freeze_i,
    input  logic              prog_vld_i,
    input  logic [ADDR_W-1:0] prog_addr_i,
    input  logic [BYTE_W-1:0] prog_data_i,
    input  logic              rd_vld_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              rd_vld_o,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              wel_o,
    output logic              perr_o
);
    localparam int unsigned OFF_W = $clog2(DEPTH);
    localparam int unsigned RG_W  = $clog2(DEPTH / REGION_BYTES);

    typedef struct packed {
        logic              wel;
        logic              perr;
        logic              rd_vld;
        logic [BYTE_W-1:0] rd_data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              p_in_range;
    logic [OFF_W-1:0]  p_off;
    logic [RG_W-1:0]   p_region;
    logic [OFF_W-1:0]  lk_off;
    logic [BYTE_W-1:0] lk_byte;
    logic              locked;
    logic [BYTE_W-1:0] rd_byte;
    logic              r_in_range;
    logic              wr_en_d;

    otp_addr_dec #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .RG_W(RG_W)) u_pdec (
        .addr_i    (prog_addr_i),
        .in_range_o(p_in_range),
        .off_o     (p_off),
        .region_o  (p_region)
    );

    otp_lock_sel #(.OFF_W(OFF_W), .RG_W(RG_W), .BYTE_W(BYTE_W), .LOCK_BASE(LOCK_BASE)) u_lsel (
        .region_i (p_region),
        .lk_byte_i(lk_byte),
        .lk_off_o (lk_off),
        .locked_o (locked)
    );

    otp_cell_array #(.DEPTH(DEPTH), .OFF_W(OFF_W), .BYTE_W(BYTE_W)) u_cells (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en_d),
        .wr_off_i (p_off),
        .wr_data_i(prog_data_i),
        .rd_off_i (rd_addr_i[OFF_W-1:0]),
        .rd_data_o(rd_byte),
        .lk_off_i (lk_off),
        .lk_data_o(lk_byte)
    );

    generate
        if (ADDR_W > OFF_W) begin : g_rhi
            assign r_in_range = (rd_addr_i[ADDR_W-1:OFF_W] == '0);
        end else begin : g_rfull
            assign r_in_range = 1'b1;
        end
    endgenerate

    always_comb begin
        ctl_d   = ctl_q;
        wr_en_d = 1'b0;
        ctl_d.rd_vld = rd_vld_i;
        if (rd_vld_i) ctl_d.rd_data = r_in_range ? rd_byte : '1;
        if (prog_vld_i && ctl_q.wel && p_in_range) begin
            ctl_d.wel = 1'b0;
            if (freeze_i || locked) ctl_d.perr = 1'b1;
            else                    wr_en_d    = 1'b1;
        end else if (wen_set_i) begin
            ctl_d.wel = 1'b1;
        end else if (wen_clr_i) begin
            ctl_d.wel = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign rd_vld_o  = ctl_q.rd_vld;
    assign rd_data_o = ctl_q.rd_data;
    assign wel_o     = ctl_q.wel;
    assign perr_o    = ctl_q.perr;

    // R4
    wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_vld_i && !wel_o && !wen_set_i) |=> (!wel_o && $stable(perr_o)));
    // R5
    oor_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_vld_i && wel_o && !p_in_range && !wen_clr_i) |=> (wel_o && $stable(perr_o)));
    // R6
    freeze_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_vld_i && wel_o && p_in_range && freeze_i) |=> (perr_o && !wel_o));
    // R7
    lock_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_vld_i && wel_o && p_in_range && locked) |=> (perr_o && !wel_o));
    // R10
    perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        perr_o |=> perr_o);
    // R2
    rd_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld_i |=> rd_vld_o);
endmodule

// File: tb/otp_prot_ctrl_bench.sv
module otp_prot_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wen_set_i = 1'b0, wen_clr_i = 1'b0, freeze_i = 1'b0;
    logic        prog_vld_i = 1'b0, rd_vld_i = 1'b0;
    logic [11:0] prog_addr_i = '0, rd_addr_i = '0;
    logic [7:0]  prog_data_i = '0;
    logic        rd_vld_o, wel_o, perr_o;
    logic [7:0]  rd_data_o;

    int tests = 0;
    int fails = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    otp_prot_ctrl u_otp_prot_ctrl (
        .clk(clk), .rst_n(rst_n), .wen_set_i(wen_set_i), .wen_clr_i(wen_clr_i),
        .freeze_i(freeze_i), .prog_vld_i(prog_vld_i), .prog_addr_i(prog_addr_i),
        .prog_data_i(prog_data_i), .rd_vld_i(rd_vld_i), .rd_addr_i(rd_addr_i),
        .rd_vld_o(rd_vld_o), .rd_data_o(rd_data_o), .wel_o(wel_o), .perr_o(perr_o)
    );

    always #10ns clk = ~clk;

    // monitor: pops expected read bytes as results appear
    always @(negedge clk) begin
        if (rst_n && rd_vld_o) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R2 unexpected read result act=%h exp=none", rd_data_o);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data_o !== e) begin
                    fails++;
                    $display("FAIL %s read act=%h exp=%h", t, rd_data_o, e);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        freeze_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wren();
        @(negedge clk); wen_set_i = 1'b1;
        @(negedge clk); wen_set_i = 1'b0;
    endtask

    task automatic prog(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk); prog_vld_i = 1'b1; prog_addr_i = a; prog_data_i = d;
        @(negedge clk); prog_vld_i = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [7:0] e, input string tag);
        @(negedge clk); rd_vld_i = 1'b1; rd_addr_i = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk); rd_vld_i = 1'b0;
    endtask

    initial begin
        #4ms;
        fails++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 wel", wel_o, 1'b0);
        chk("R1 perr", perr_o, 1'b0);
        rd(12'h000, 8'hFF, "R1");
        rd(12'h3FF, 8'hFF, "R1");

        // R4 program without latch ignored
        prog(12'h005, 8'h00);
        chk("R4 wel", wel_o, 1'b0);
        chk("R4 perr", perr_o, 1'b0);
        rd(12'h005, 8'hFF, "R4");

        // R9 set/clear
        wren();
        chk("R9 set", wel_o, 1'b1);
        @(negedge clk); wen_clr_i = 1'b1;
        @(negedge clk); wen_clr_i = 1'b0;
        chk("R9 clr", wel_o, 1'b0);
        @(negedge clk); wen_clr_i = 1'b1; wen_set_i = 1'b1;
        @(negedge clk); wen_clr_i = 1'b0; wen_set_i = 1'b0;
        chk("R9 set wins", wel_o, 1'b1);

        // R3 AND semantics
        prog(12'h005, 8'h3C);
        chk("R9 clear on done", wel_o, 1'b0);
        rd(12'h005, 8'h3C, "R3");
        wren(); prog(12'h005, 8'h0F);
        rd(12'h005, 8'h0C, "R3");
        wren(); prog(12'h005, 8'hFF);
        rd(12'h005, 8'h0C, "R3 no rise");

        // R5 out of range (aliases offset 0)
        wren(); prog(12'h400, 8'h00);
        chk("R5 wel", wel_o, 1'b1);
        chk("R5 perr", perr_o, 1'b0);
        rd(12'h000, 8'hFF, "R5");

        // R2 same-cycle read and program of one byte
        @(negedge clk);
        prog_vld_i = 1'b1; prog_addr_i = 12'h080; prog_data_i = 8'h12;
        rd_vld_i = 1'b1; rd_addr_i = 12'h080;
        exp_q.push_back(8'hFF); tag_q.push_back("R2 old value");
        @(negedge clk); prog_vld_i = 1'b0; rd_vld_i = 1'b0;
        rd(12'h080, 8'h12, "R2 new value");

        // R9 set with program while latch 0: program judged on old latch
        @(negedge clk);
        wen_set_i = 1'b1; prog_vld_i = 1'b1; prog_addr_i = 12'h081; prog_data_i = 8'h00;
        @(negedge clk); wen_set_i = 1'b0; prog_vld_i = 1'b0;
        chk("R9 set beside dropped prog", wel_o, 1'b1);
        rd(12'h081, 8'hFF, "R9 dropped prog");

        // R7 lock region 16 via byte 0x12 bit 0
        wren(); prog(12'h012, 8'hFE);
        wren(); prog(12'h220, 8'h11);
        chk("R7 neighbour perr", perr_o, 1'b0);
        rd(12'h220, 8'h11, "R7 neighbour");
        wren(); prog(12'h200, 8'h00);
        chk("R7 perr", perr_o, 1'b1);
        chk("R7 wel", wel_o, 1'b0);
        rd(12'h200, 8'hFF, "R7 locked");
        // R10 sticky
        wren(); prog(12'h300, 8'h55);
        chk("R10 sticky", perr_o, 1'b1);
        rd(12'h300, 8'h55, "R10 later write");

        // R7 MSB of byte 0x13 protects region 31
        do_reset();
        wren(); prog(12'h013, 8'h7F);
        wren(); prog(12'h3E0, 8'h00);
        chk("R7 msb perr", perr_o, 1'b1);
        rd(12'h3E0, 8'hFF, "R7 msb");

        // R8 region 0 lock freezes lock bytes
        do_reset();
        wren(); prog(12'h010, 8'hFE);
        chk("R8 lock set perr", perr_o, 1'b0);
        wren(); prog(12'h011, 8'h00);
        chk("R8 perr", perr_o, 1'b1);
        rd(12'h011, 8'hFF, "R8 lock byte");
        rd(12'h010, 8'hFE, "R8 own byte");

        // R6 freeze
        do_reset();
        freeze_i = 1'b1;
        wren(); prog(12'h040, 8'h00);
        chk("R6 perr", perr_o, 1'b1);
        chk("R6 wel", wel_o, 1'b0);
        rd(12'h040, 8'hFF, "R6");
        freeze_i = 1'b0;

        repeat (4) @(negedge clk);
        tests++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R2 missing reads act=%0d exp=0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule